// File: doc/BRIEF.md
# Buck Converter Start-up and Protection Sequencer

This block decides when a synchronous step-down converter may switch and where its error-amplifier reference sits. It runs on the switching-cycle clock and reads digitized comparator flags: supply ready, enable above its threshold, feedback below the under-voltage level, over-current trip, compensation pin pulled to shutdown, and two power-good flags. The power-good flags are the rising-edge threshold and the lower falling-edge threshold, which together give the hysteresis. From these it produces an 11-bit reference code, a driver enable, a latched-fault flag and a power-good flag.

A start needs supply ready and enable both high. The reference then ramps by one code per cycle for 2048 cycles and holds at full scale. A feedback under-voltage seen during regulation stops the drivers and waits 2048 cycles before a fresh ramp begins. This is the hiccup response. The under-voltage flag is ignored while the ramp is still rising. An over-current trip during ramp or regulation latches the drivers off. Only loss of supply ready or of enable clears that latch. A shutdown request on the compensation pin stops the converter, and a new ramp starts when the request is released.

The checks are applied in a fixed priority order. Loss of supply ready or enable comes first. The fault latch comes next, then the over-current trip, then shutdown, and last the normal state progression.

Top module: `buck_start_seq`

## Requirements
- R1: While reset is asserted, and on the first cycle after it, ref_code is 0 and drv_en, fault_latched and pwr_good are 0.
- R2: From the off state, with por_ok and en_ok high, comp_low low and no fault latched, drv_en rises on the next cycle with ref_code 0. ref_code then rises by exactly one per cycle up to 2047 and holds at 2047 after the 2048-cycle ramp.
- R3: One cycle after por_ok or en_ok is sampled low, ref_code is 0 and drv_en is 0, whatever the other inputs are.
- R4: In regulation, an fb_uv sampled high turns drv_en off and ref_code to 0 on the next cycle. The drivers stay off for 2048 cycles, and then a ramp restarts from code 0.
- R5: An oc_trip sampled high while drv_en is high sets fault_latched on the next cycle. While fault_latched is high, drv_en and ref_code are 0.
- R6: fault_latched stays high as long as por_ok and en_ok stay high, whatever oc_trip, comp_low and fb_uv do. It clears one cycle after either of them is sampled low, and a fresh ramp follows once both are high again.
- R7: When no fault is latched, comp_low sampled high turns drv_en off on the next cycle. After comp_low is released, the ramp restarts from code 0.
- R8: fb_uv has no effect while the ramp is rising.
- R9: In regulation, pwr_good rises one cycle after pg_hi is sampled high. Once high, it stays high while pg_lo is high and falls one cycle after pg_lo is sampled low.
- R10: pwr_good is 0 outside regulation and on the first regulation cycle. Whenever pwr_good is high, drv_en is high and ref_code is 2047.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Switching-cycle clock |
| rst_n | input | 1 | Synchronous active-low reset |
| por_ok | input | 1 | Supply ready flag |
| en_ok | input | 1 | Enable above threshold flag |
| fb_uv | input | 1 | Feedback below under-voltage level |
| oc_trip | input | 1 | Over-current comparator trip |
| comp_low | input | 1 | Compensation pin pulled to shutdown |
| pg_hi | input | 1 | Feedback above power-good rising threshold |
| pg_lo | input | 1 | Feedback above power-good falling threshold |
| ref_code | output | 11 | Soft-start reference code |
| drv_en | output | 1 | Gate driver enable |
| fault_latched | output | 1 | Over-current latch-off active |
| pwr_good | output | 1 | Output in regulation and within window |

## Verification
Every output is a decode of registered state, so each response is due exactly one clock edge after the input that causes it. The start ramp ends 2048 edges after drv_en rises. The hiccup wait releases 2048 edges after the under-voltage edge. Power-good follows its threshold flags with one edge of delay. The bench drives inputs on the falling edge and advances a cycle-level reference model on the rising edge. It compares all four outputs at the next falling edge, so each expected value is taken in the cycle its result is due. The directed sequences count these windows exactly, checking the last off cycle and the first on cycle on either side of each boundary.

// File: rtl/ss_pkg.sv
// Shared types for the buck start-up sequencer.
// Assumes: one-hot coding is not required; states are binary encoded.
package ss_pkg;
    typedef enum logic [2:0] {
        SS_OFF   = 3'd0,
        SS_RAMP  = 3'd1,
        SS_REG   = 3'd2,
        SS_WAIT  = 3'd3,
        SS_LATCH = 3'd4
    } ss_state_e;
endpackage

// File: rtl/ss_cycle_counter.sv
// Free-running up counter with synchronous clear, used to time the
// reference ramp and the hiccup wait.
// Assumes: clr has priority over inc; the count wraps if inc is held
// beyond the top value (the controller never lets that happen).
module ss_cycle_counter #(
    parameter int W = 11
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         inc,
    output logic [W-1:0] count
);
    // Count switching cycles while inc is high; restart from zero on clr.
    always_ff @(posedge clk) begin
        if (!rst_n)      count <= '0;
        else if (clr)    count <= '0;
        else if (inc)    count <= count + 1'b1;
    end
endmodule

// File: rtl/ss_pgood_track.sv
// Power-good tracker with hysteresis built from two threshold flags.
// Assumes: above_lo is high whenever above_hi is high; output is gated
// by in_reg so it drops in the same cycle regulation is left.
module ss_pgood_track (
    input  logic clk,
    input  logic rst_n,
    input  logic in_reg,
    input  logic above_hi,
    input  logic above_lo,
    output logic pg_o
);
    logic pg_q;

    // Set on the rising threshold, hold until the falling threshold is lost.
    always_ff @(posedge clk) begin
        if (!rst_n)       pg_q <= 1'b0;
        else if (!in_reg) pg_q <= 1'b0;
        else if (pg_q)    pg_q <= above_lo;
        else              pg_q <= above_hi;
    end

    assign pg_o = pg_q & in_reg;
endmodule

// File: rtl/ss_seq_fsm.sv
// Sequencing state machine: start, ramp, regulate, hiccup wait, latch-off.
// Assumes: ramp_done and wait_done are terminal-count flags of counters
// cleared whenever their state is not active.
module ss_seq_fsm
    import ss_pkg::*;
(
    input  logic      clk,
    input  logic      rst_n,
    input  logic      por_ok,
    input  logic      en_ok,
    input  logic      fb_uv,
    input  logic      oc_trip,
    input  logic      comp_low,
    input  logic      ramp_done,
    input  logic      wait_done,
    output ss_state_e state
);
    ss_state_e nxt;

    // Next-state choice in priority order: gate, latch, trip, shutdown, progress.
    always_comb begin
        nxt = state;
        if (!por_ok || !en_ok) begin
            nxt = SS_OFF;
        end else if (state == SS_LATCH) begin
            nxt = SS_LATCH;
        end else if (oc_trip && (state == SS_RAMP || state == SS_REG)) begin
            nxt = SS_LATCH;
        end else if (comp_low) begin
            nxt = SS_OFF;
        end else begin
            unique case (state)
                SS_OFF:  nxt = SS_RAMP;
                SS_RAMP: nxt = ramp_done ? SS_REG : SS_RAMP;
                SS_REG:  nxt = fb_uv ? SS_WAIT : SS_REG;
                SS_WAIT: nxt = wait_done ? SS_RAMP : SS_WAIT;
                default: nxt = SS_OFF;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= SS_OFF;
        else        state <= nxt;
    end
endmodule

// File: rtl/buck_start_seq.sv
// Top of the start-up and protection sequencer for a buck controller.
// Assumes: clocked once per switching cycle; all inputs are already
// synchronous digital comparator flags.
module buck_start_seq
    import ss_pkg::*;
#(
    parameter int CODE_W        = 11,
    parameter int HICCUP_CYCLES = 2048
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              por_ok,
    input  logic              en_ok,
    input  logic              fb_uv,
    input  logic              oc_trip,
    input  logic              comp_low,
    input  logic              pg_hi,
    input  logic              pg_lo,
    output logic [CODE_W-1:0] ref_code,
    output logic              drv_en,
    output logic              fault_latched,
    output logic              pwr_good
);
    localparam int                HIC_W    = (HICCUP_CYCLES > 1) ? $clog2(HICCUP_CYCLES) : 1;
    localparam logic [CODE_W-1:0] CODE_TOP = {CODE_W{1'b1}};
    localparam logic [HIC_W-1:0]  WAIT_TOP = HIC_W'(HICCUP_CYCLES - 1);

    ss_state_e          state;
    logic [CODE_W-1:0]  ramp_cnt;
    logic [HIC_W-1:0]   wait_cnt;
    logic               in_ramp;
    logic               in_wait;
    logic               in_reg;

    assign in_ramp = (state == SS_RAMP);
    assign in_wait = (state == SS_WAIT);
    assign in_reg  = (state == SS_REG);

    ss_cycle_counter #(.W(CODE_W)) u_ramp_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!in_ramp),
        .inc   (in_ramp),
        .count (ramp_cnt)
    );

    ss_cycle_counter #(.W(HIC_W)) u_wait_cnt (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (!in_wait),
        .inc   (in_wait),
        .count (wait_cnt)
    );

    ss_seq_fsm u_fsm (
        .clk       (clk),
        .rst_n     (rst_n),
        .por_ok    (por_ok),
        .en_ok     (en_ok),
        .fb_uv     (fb_uv),
        .oc_trip   (oc_trip),
        .comp_low  (comp_low),
        .ramp_done (ramp_cnt == CODE_TOP),
        .wait_done (wait_cnt == WAIT_TOP),
        .state     (state)
    );

    ss_pgood_track u_pg (
        .clk      (clk),
        .rst_n    (rst_n),
        .in_reg   (in_reg),
        .above_hi (pg_hi),
        .above_lo (pg_lo),
        .pg_o     (pwr_good)
    );

    // Output decode from the registered state and ramp count.
    always_comb begin
        ref_code = '0;
        if (in_ramp)     ref_code = ramp_cnt;
        else if (in_reg) ref_code = CODE_TOP;
    end

    assign drv_en        = in_ramp | in_reg;
    assign fault_latched = (state == SS_LATCH);
endmodule

// File: rtl/buck_start_seq_chk.sv
// Property checker for buck_start_seq, attached by bind below.
module buck_start_seq_chk #(
    parameter int CODE_W = 11
) (
    input logic              clk,
    input logic              rst_n,
    input logic              por_ok,
    input logic              en_ok,
    input logic              fb_uv,
    input logic              oc_trip,
    input logic              comp_low,
    input logic [CODE_W-1:0] ref_code,
    input logic              drv_en,
    input logic              fault_latched,
    input logic              pwr_good
);
    localparam logic [CODE_W-1:0] TOP = {CODE_W{1'b1}};

    AST_GATE_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        (!por_ok || !en_ok) |=> (!drv_en && ref_code == '0 && !fault_latched)); // R3

    AST_LATCH_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
        fault_latched |-> (!drv_en && ref_code == '0)); // R5

    AST_TRIP_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en && oc_trip && por_ok && en_ok) |=> fault_latched); // R5

    AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (fault_latched && por_ok && en_ok) |=> fault_latched); // R6

    AST_RAMP_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (drv_en && ref_code != TOP && por_ok && en_ok && !oc_trip && !comp_low)
        |=> (drv_en && ref_code == CODE_W'($past(ref_code) + 1'b1))); // R2

    AST_SHUTDOWN: assert property (@(posedge clk) disable iff (!rst_n)
        comp_low |=> !drv_en); // R7

    AST_PG_WINDOW: assert property (@(posedge clk) disable iff (!rst_n)
        pwr_good |-> (drv_en && ref_code == TOP)); // R10
endmodule

bind buck_start_seq buck_start_seq_chk #(.CODE_W(CODE_W)) u_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .por_ok        (por_ok),
    .en_ok         (en_ok),
    .fb_uv         (fb_uv),
    .oc_trip       (oc_trip),
    .comp_low      (comp_low),
    .ref_code      (ref_code),
    .drv_en        (drv_en),
    .fault_latched (fault_latched),
    .pwr_good      (pwr_good)
);

// File: tb/sim_buck_start_seq.sv
module sim_buck_start_seq;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        por_ok = 1'b0, en_ok = 1'b0, fb_uv = 1'b0, oc_trip = 1'b0;
    logic        comp_low = 1'b0, pg_hi = 1'b0, pg_lo = 1'b0;
    logic [10:0] ref_code;
    logic        drv_en, fault_latched, pwr_good;

    int n_chk = 0;
    int n_fail = 0;

    // reference model state: 0 off, 1 ramp, 2 regulate, 3 wait, 4 latched
    int m_st = 0;
    int m_cnt = 0;
    bit m_pg = 1'b0;

    always #4 clk = ~clk;

    buck_start_seq u0 (
        .clk(clk), .rst_n(rst_n), .por_ok(por_ok), .en_ok(en_ok),
        .fb_uv(fb_uv), .oc_trip(oc_trip), .comp_low(comp_low),
        .pg_hi(pg_hi), .pg_lo(pg_lo), .ref_code(ref_code),
        .drv_en(drv_en), .fault_latched(fault_latched), .pwr_good(pwr_good)
    );

    function automatic int exp_ref();
        if (m_st == 1) return m_cnt;
        if (m_st == 2) return 2047;
        return 0;
    endfunction

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s at %0t: actual %0d expected %0d", tag, $time, act, exp);
        end
    endtask

    task automatic model_step();
        int st_old = m_st;
        if (!rst_n) begin
            m_st = 0; m_cnt = 0; m_pg = 0;
            return;
        end
        m_pg = (st_old == 2) ? (m_pg ? pg_lo : pg_hi) : 1'b0;
        if (!por_ok || !en_ok) begin
            m_st = 0;
        end else if (st_old == 4) begin
            m_st = 4;
        end else if (oc_trip && (st_old == 1 || st_old == 2)) begin
            m_st = 4;
        end else if (comp_low) begin
            m_st = 0;
        end else begin
            case (st_old)
                0: begin m_st = 1; m_cnt = 0; end
                1: if (m_cnt == 2047) m_st = 2; else m_cnt++;
                2: if (fb_uv) begin m_st = 3; m_cnt = 0; end
                3: if (m_cnt == 2047) begin m_st = 1; m_cnt = 0; end else m_cnt++;
                default: m_st = 0;
            endcase
        end
        if (m_st == 1 && st_old != 1) m_cnt = 0;
    endtask

    // One clock: advance the model on the rising edge, compare on the falling edge.
    task automatic tick(input int n = 1);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            model_step();
            @(negedge clk);
            chk("R2 ref_code", int'(ref_code), exp_ref());
            chk("R4 drv_en", int'(drv_en), (m_st == 1 || m_st == 2) ? 1 : 0);
            chk("R5 fault_latched", int'(fault_latched), (m_st == 4) ? 1 : 0);
            chk("R9 pwr_good", int'(pwr_good), (m_pg && m_st == 2) ? 1 : 0);
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        void'($urandom(32'd1234));
        @(negedge clk);
        tick(3);
        chk("R1 ref", int'(ref_code), 0);
        chk("R1 drv", int'(drv_en), 0);
        chk("R1 fault", int'(fault_latched), 0);
        chk("R1 pg", int'(pwr_good), 0);
        rst_n = 1'b1;
        tick(1);
        chk("R1 after release", int'(drv_en), 0);

        // start and ramp, with under-voltage asserted during the ramp
        por_ok = 1; en_ok = 1; pg_hi = 1; pg_lo = 1; fb_uv = 1;
        tick(1);
        chk("R2 start drv", int'(drv_en), 1);
        chk("R2 start ref", int'(ref_code), 0);
        tick(100);
        chk("R8 uv ignored ref", int'(ref_code), 100);
        chk("R8 uv ignored drv", int'(drv_en), 1);
        fb_uv = 0;
        tick(1947);
        chk("R2 last ramp code", int'(ref_code), 2047);
        tick(1);
        chk("R2 hold top", int'(ref_code), 2047);
        chk("R10 first reg cycle pg", int'(pwr_good), 0);
        tick(1);
        chk("R9 pg rises", int'(pwr_good), 1);

        // hysteresis
        pg_hi = 0;
        tick(3);
        chk("R9 pg held on lo", int'(pwr_good), 1);
        pg_lo = 0;
        tick(1);
        chk("R9 pg falls", int'(pwr_good), 0);
        pg_lo = 1;
        tick(1);
        chk("R9 pg needs hi", int'(pwr_good), 0);
        pg_hi = 1;
        tick(2);

        // hiccup
        fb_uv = 1;
        tick(1);
        fb_uv = 0;
        chk("R4 hiccup off", int'(drv_en), 0);
        chk("R10 pg off in wait", int'(pwr_good), 0);
        tick(2047);
        chk("R4 still waiting", int'(drv_en), 0);
        tick(1);
        chk("R4 restart drv", int'(drv_en), 1);
        chk("R4 restart ref", int'(ref_code), 0);

        // over-current latch
        tick(20);
        oc_trip = 1;
        tick(1);
        oc_trip = 0;
        chk("R5 latched", int'(fault_latched), 1);
        comp_low = 1; fb_uv = 1;
        tick(5);
        chk("R6 latch holds", int'(fault_latched), 1);
        comp_low = 0; fb_uv = 0;
        tick(3);
        chk("R6 latch holds drv", int'(drv_en), 0);
        en_ok = 0;
        tick(1);
        chk("R6 latch cleared", int'(fault_latched), 0);
        chk("R3 enable low ref", int'(ref_code), 0);
        en_ok = 1;
        tick(1);
        chk("R6 fresh ramp", int'(drv_en), 1);
        chk("R6 fresh ramp ref", int'(ref_code), 0);

        // compensation shutdown
        tick(50);
        comp_low = 1;
        tick(1);
        chk("R7 shutdown", int'(drv_en), 0);
        comp_low = 0;
        tick(1);
        chk("R7 restart", int'(drv_en), 1);
        chk("R7 restart ref", int'(ref_code), 0);

        // supply loss
        tick(30);
        por_ok = 0;
        tick(1);
        chk("R3 por low drv", int'(drv_en), 0);
        chk("R3 por low ref", int'(ref_code), 0);
        por_ok = 1;

        // constrained random phase
        for (int i = 0; i < 60000; i++) begin
            por_ok   = ($urandom % 6000) != 0;
            en_ok    = ($urandom % 5000) != 0;
            oc_trip  = ($urandom % 7000) == 0;
            comp_low = ($urandom % 4000) == 0;
            fb_uv    = ($urandom % 1800) == 0;
            pg_lo    = ($urandom % 8) != 0;
            pg_hi    = pg_lo && ($urandom % 2);
            tick(1);
        end

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule